// File: doc/BRIEF.md
# Scalar Single-to-Double Precision Widener

This block takes one IEEE-754 binary32 value from the lowest 32-bit lane of a 128-bit source vector and produces its exact binary64 equivalent. The 64-bit result replaces the low half of a 128-bit destination vector supplied in the same beat. The upper half of that destination is carried through untouched. Widening never loses precision, so no rounding mode is involved.

Every class of input has a defined result. Zeros and infinities keep their sign. Normal numbers are re-biased. Single-precision subnormals become ordinary double-precision normals after a leading-zero count. Quiet NaNs pass through, and signaling NaNs are quieted. Two status flags accompany each result: one for an invalid operation and one for a denormal operand.

The interface is one register stage. A beat presented with `in_valid` high appears on the outputs one clock later with `out_valid` high.

Top module: `fpw_widener`

## Requirements
- R1: Only bits [31:0] of `src_vec` select the result; bits [127:32] have no effect on any output.
- R2: Bits [127:64] of `out_vec` equal bits [127:64] of the `dst_vec` presented in the same beat.
- R3: `out_valid` is the value of `in_valid` one clock earlier. After reset, `out_valid`, `out_vec` and both flags are zero.
- R4: A normal input (exponent field 1..254) gives exponent field plus 896 in bits [62:52], the 23 fraction bits followed by 29 zeros in bits [51:0], the same sign, and both flags low.
- R5: A zero input (exponent 0, fraction 0) gives a zero with the same sign in bit 63 and both flags low.
- R6: An infinity (exponent 255, fraction 0) gives exponent 0x7FF, fraction 0, the same sign, and both flags low.
- R7: A subnormal input (exponent 0, fraction nonzero) raises `out_denormal` and gives an exact normal result. With z the number of leading zeros in the 23-bit fraction, the exponent field is 896 − z. The fraction is the input fraction shifted left by z+1, truncated to 23 bits, then followed by 29 zeros.
- R8: A signaling NaN (exponent 255, fraction bit 22 clear, fraction nonzero) raises `out_invalid`. It gives exponent 0x7FF, bit 51 set, fraction bits 21..0 in bits [50:29], zeros below, and the same sign.
- R9: A quiet NaN (exponent 255, fraction bit 22 set) produces the same NaN layout as R8 with both flags low.
- R10: In a cycle after `in_valid` was low, `out_vec` holds its previous value and both flags are low. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source and destination vectors are valid this cycle |
| src_vec | input | 128 | Source vector; the low 32 bits hold the binary32 operand |
| dst_vec | input | 128 | Destination vector whose upper half is kept |
| out_valid | output | 1 | Result beat valid |
| out_vec | output | 128 | Merged result vector |
| out_invalid | output | 1 | Invalid-operation status for the beat |
| out_denormal | output | 1 | Denormal-operand status for the beat |

## Verification
In every beat, the lane merge of the destination's upper half and the special-case conversion of the low lane happen in the same cycle. The riskiest cases are the signaling-NaN quieting and the subnormal normalization, since each also raises a status flag. The bench provokes these collisions by streaming back-to-back beats. Each beat has a random upper destination word, random upper source bits, and a low lane whose class is drawn at random or forced to a boundary value. Each beat is judged one cycle later by comparing all 128 output bits and both flags against a bench model. That model normalizes subnormals with a shift loop instead of a count. Idle cycles between streams confirm that the held vector and the quiet flags survive changing inputs.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  localparam int SP_W     = 32;
  localparam int SP_EW    = 8;
  localparam int SP_FW    = 23;
  localparam int DP_W     = 64;
  localparam int DP_EW    = 11;
  localparam int DP_FW    = 52;
  localparam int SP_BIAS  = (1 << (SP_EW - 1)) - 1;
  localparam int DP_BIAS  = (1 << (DP_EW - 1)) - 1;
  localparam int BIAS_GAP = DP_BIAS - SP_BIAS;
  localparam int FRAC_PAD = DP_FW - SP_FW;
  localparam int LZ_W     = $clog2(SP_FW + 1);

  typedef enum logic [2:0] {
    K_ZERO, K_SUB, K_NORM, K_INF, K_QNAN, K_SNAN
  } fp_kind_e;

  typedef struct packed {
    logic             sign;
    logic [SP_EW-1:0] exp;
    logic [SP_FW-1:0] frac;
  } sp_t;

  typedef struct packed {
    logic             sign;
    logic [DP_EW-1:0] exp;
    logic [DP_FW-1:0] frac;
  } dp_t;

  function automatic fp_kind_e kind_of(sp_t v);
    fp_kind_e k;
    if (v.exp == '0)
      k = (v.frac == '0) ? K_ZERO : K_SUB;
    else if (v.exp == '1) begin
      if (v.frac == '0)              k = K_INF;
      else if (v.frac[SP_FW-1])      k = K_QNAN;
      else                           k = K_SNAN;
    end else
      k = K_NORM;
    return k;
  endfunction

  function automatic logic [DP_EW-1:0] rebias_normal(logic [SP_EW-1:0] e);
    return DP_EW'(e) + DP_EW'(BIAS_GAP);
  endfunction

  function automatic logic [DP_EW-1:0] rebias_sub(logic [LZ_W-1:0] lz);
    return DP_EW'(BIAS_GAP) - DP_EW'(lz);
  endfunction

  function automatic logic [DP_FW-1:0] pad_frac(logic [SP_FW-1:0] f);
    return {f, {FRAC_PAD{1'b0}}};
  endfunction

  function automatic logic [SP_FW-1:0] drop_lead(logic [SP_FW-1:0] f,
                                                  logic [LZ_W-1:0] lz);
    logic [SP_FW-1:0] t;
    t = f << lz;
    return {t[SP_FW-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          all_zero
);

  logic [W-1:0] seen;

  assign seen[W-1] = vec[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_prefix
    assign seen[i] = seen[i+1] | vec[i];
  end

  assign count    = CW'($countones(~seen));
  assign all_zero = ~seen[0];

endmodule

// File: rtl/fpw_classify.sv
module fpw_classify
  import fpw_pkg::*;
(
  input  sp_t      operand,
  output fp_kind_e kind,
  output logic     is_nan
);

  assign kind   = kind_of(operand);
  assign is_nan = (kind == K_QNAN) || (kind == K_SNAN);

endmodule

// File: rtl/fpw_widen_core.sv
module fpw_widen_core
  import fpw_pkg::*;
(
  input  sp_t             operand,
  input  fp_kind_e        kind,
  input  logic [LZ_W-1:0] lz,
  output dp_t             result,
  output logic            raise_invalid,
  output logic            raise_denormal
);

  always_comb begin
    result.sign    = operand.sign;
    result.exp     = '0;
    result.frac    = '0;
    raise_invalid  = 1'b0;
    raise_denormal = 1'b0;
    case (kind)
      K_ZERO: ;
      K_SUB: begin
        result.exp     = rebias_sub(lz);
        result.frac    = pad_frac(drop_lead(operand.frac, lz));
        raise_denormal = 1'b1;
      end
      K_NORM: begin
        result.exp  = rebias_normal(operand.exp);
        result.frac = pad_frac(operand.frac);
      end
      K_INF: result.exp = '1;
      K_QNAN, K_SNAN: begin
        result.exp           = '1;
        result.frac          = pad_frac(operand.frac);
        result.frac[DP_FW-1] = 1'b1;
        raise_invalid        = (kind == K_SNAN);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fpw_widener.sv
module fpw_widener
  import fpw_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_invalid,
  output logic             out_denormal
);

  localparam int KEEP_W = VEC_W - DP_W;

  sp_t             src_lane;
  fp_kind_e        lane_kind;
  logic            lane_is_nan;
  logic [LZ_W-1:0] lane_lz;
  logic            lane_frac_zero;
  dp_t             wide;
  logic            core_invalid;
  logic            core_denormal;

  // Named events for the assertions
  logic ev_sub, ev_snan, ev_qnan, ev_zero, ev_norm;

  assign src_lane = src_vec[SP_W-1:0];

  fpw_classify u_classify (
    .operand (src_lane),
    .kind    (lane_kind),
    .is_nan  (lane_is_nan)
  );

  fpw_lzc #(.W(SP_FW), .CW(LZ_W)) u_lzc (
    .vec      (src_lane.frac),
    .count    (lane_lz),
    .all_zero (lane_frac_zero)
  );

  fpw_widen_core u_core (
    .operand        (src_lane),
    .kind           (lane_kind),
    .lz             (lane_lz),
    .result         (wide),
    .raise_invalid  (core_invalid),
    .raise_denormal (core_denormal)
  );

  assign ev_sub  = in_valid && (lane_kind == K_SUB);
  assign ev_snan = in_valid && (lane_kind == K_SNAN);
  assign ev_qnan = in_valid && (lane_kind == K_QNAN);
  assign ev_zero = in_valid && (lane_kind == K_ZERO);
  assign ev_norm = in_valid && (lane_kind == K_NORM);

  logic unused_bits;
  assign unused_bits = ^{src_vec[VEC_W-1:SP_W], dst_vec[DP_W-1:0], lane_is_nan};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_vec      <= '0;
      out_invalid  <= 1'b0;
      out_denormal <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_invalid  <= in_valid & core_invalid;
      out_denormal <= in_valid & core_denormal;
      if (in_valid)
        out_vec <= {dst_vec[VEC_W-1:DP_W], wide};
    end
  end

  // R3: one-stage latency
  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R2: destination upper half merged through
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[VEC_W-1:DP_W] == $past(dst_vec[VEC_W-1:DP_W]));

  // R10: hold and quiet flags on idle
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec) && !out_invalid && !out_denormal);

  // R10: flags exclusive
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_invalid, out_denormal}) <= 1);

  // R7: subnormal lands in the narrow exponent window
  a_r7_sub_window: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sub |=> out_denormal && !lane_frac_zero_q
      && out_vec[62:52] <= 11'(BIAS_GAP)
      && out_vec[62:52] >= 11'(BIAS_GAP - SP_FW + 1));

  // R8: signaling NaN is quieted and flagged
  a_r8_snan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snan |=> out_invalid && out_vec[DP_FW-1] && out_vec[62:52] == '1);

  // R9: quiet NaN passes with no flag
  a_r9_qnan_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ev_qnan |=> !out_invalid && !out_denormal && out_vec[DP_FW-1]);

  // R5: signed zero
  a_r5_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> out_vec[62:0] == '0 && out_vec[63] == $past(src_vec[SP_W-1]));

  // R4: normals raise no flag
  a_r4_norm_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ev_norm |=> !out_invalid && !out_denormal);

  logic lane_frac_zero_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lane_frac_zero_q <= 1'b0;
    else        lane_frac_zero_q <= lane_frac_zero;
  end

endmodule

// File: tb/fpw_widener_tb.sv
module fpw_widener_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [127:0] dst_vec;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         out_invalid;
  logic         out_denormal;

  int checks   = 0;
  int failures = 0;
  logic [127:0] last_out;

  always #4 clk = ~clk;

  fpw_widener u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_vec      (src_vec),
    .dst_vec      (dst_vec),
    .out_valid    (out_valid),
    .out_vec      (out_vec),
    .out_invalid  (out_invalid),
    .out_denormal (out_denormal)
  );

  function automatic void ref_widen(input logic [31:0] x, output logic [63:0] r,
                                    output logic inv, output logic den);
    logic       s = x[31];
    logic [7:0] e = x[30:23];
    logic [22:0] f = x[22:0];
    inv = 1'b0;
    den = 1'b0;
    if (e == 8'hFF) begin
      if (f == 0) r = {s, 11'h7FF, 52'h0};
      else begin
        inv = ~f[22];
        r = {s, 11'h7FF, 1'b1, f[21:0], 29'h0};
      end
    end else if (e == 0) begin
      if (f == 0) r = {s, 63'h0};
      else begin
        int ue = -126;
        logic [23:0] m = {1'b0, f};
        den = 1'b1;
        while (!m[23]) begin
          m = m << 1;
          ue--;
        end
        r = {s, 11'(ue + 1023), m[22:0], 29'h0};
      end
    end else
      r = {s, 11'(int'(e) - 127 + 1023), f, 29'h0};
  endfunction

  function automatic string req_of(input logic [31:0] x);
    if (x[30:23] == 8'hFF) return (x[22:0] == 0) ? "R6" : (x[22] ? "R9" : "R8");
    if (x[30:23] == 0)     return (x[22:0] == 0) ? "R5" : "R7";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [127:0] s, input logic [127:0] d, input string tag);
    logic [63:0] er;
    logic ei, ed;
    in_valid = 1'b1;
    src_vec  = s;
    dst_vec  = d;
    ref_widen(s[31:0], er, ei, ed);
    @(negedge clk);
    check(out_valid == 1'b1, "R3", 128'(out_valid), 128'(1));
    check(out_vec[63:0] == er, tag, 128'(out_vec[63:0]), 128'(er));
    check(out_vec[127:64] == d[127:64], "R2", 128'(out_vec[127:64]), 128'(d[127:64]));
    check({out_invalid, out_denormal} == {ei, ed}, tag,
          128'({out_invalid, out_denormal}), 128'({ei, ed}));
    last_out = out_vec;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    src_vec  = {$urandom, $urandom, $urandom, $urandom};
    dst_vec  = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    check(out_valid == 1'b0, "R3", 128'(out_valid), 128'(0));
    check(out_vec == last_out, "R10", out_vec, last_out);
    check({out_invalid, out_denormal} == 2'b00, "R10",
          128'({out_invalid, out_denormal}), 128'(0));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] rnd_lane();
    logic [31:0] v = $urandom;
    case ($urandom % 6)
      0: v[30:0] = 31'h0;
      1: begin v[30:23] = 8'h00; if (v[22:0] == 0) v[0] = 1'b1; end
      2: if (v[30:23] == 8'h00 || v[30:23] == 8'hFF) v[30:23] = 8'h40;
      3: v[30:0] = {8'hFF, 23'h0};
      4: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
      default: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 0) v[5] = 1'b1; end
    endcase
    return v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '1; dst_vec = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0 && out_vec == '0 && !out_invalid && !out_denormal,
          "R3", out_vec, 128'(0));
    last_out = out_vec;

    // Directed corners
    beat({rnd128() & ~128'hFFFF_FFFF},                    rnd128(), "R5");
    beat({96'h0, 32'h8000_0000},                           rnd128(), "R5");
    beat({96'h0, 32'h7F80_0000},                           rnd128(), "R6");
    beat({96'h0, 32'hFF80_0000},                           rnd128(), "R6");
    beat({96'h0, 32'h3F80_0000},                           rnd128(), "R4");
    beat({96'h0, 32'h7F7F_FFFF},                           rnd128(), "R4");
    beat({96'h0, 32'h0080_0000},                           rnd128(), "R4");
    beat({96'h0, 32'h0000_0001},                           rnd128(), "R7");
    beat({96'h0, 32'h807F_FFFF},                           rnd128(), "R7");
    beat({96'h0, 32'h0040_0000},                           rnd128(), "R7");
    beat({96'h0, 32'h7F80_0001},                           rnd128(), "R8");
    beat({96'h0, 32'hFFBF_FFFF},                           rnd128(), "R8");
    beat({96'h0, 32'h7FC0_0000},                           rnd128(), "R9");
    beat({96'h0, 32'hFFC1_2345},                           rnd128(), "R9");
    // R1: upper source bits do not matter
    beat({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h4049_0FDB}, rnd128(), "R1");
    beat({96'hA5A5_5A5A_0F0F_F0F0_1234_5678, 32'h4049_0FDB}, rnd128(), "R1");
    idle();
    idle();

    // Random streaming with occasional idles
    for (int i = 0; i < 600; i++) begin
      logic [31:0] lane = rnd_lane();
      logic [127:0] s = rnd128();
      s[31:0] = lane;
      if ($urandom % 8 == 0) idle();
      beat(s, rnd128(), req_of(lane));
    end
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule